// File: doc/BRIEF.md
# Byte-Serial Storage XOR Engine

The engine combines two byte fields held in memory with a bitwise exclusive OR and writes the result over the destination field. A single start pulse hands it a destination address, a source address and an 8-bit length code; it then walks both fields from the lowest address upward. For every byte it reads the source, reads the destination, and stores the combined byte back to the destination before it touches the next byte. Because every store lands before the next fetch, fields that overlap give byte-serial results: later bytes see results already written.

An immediate variant takes its source byte from an input pin, so it makes exactly one read and one write of a single destination byte. When it finishes, the engine raises a one-cycle completion pulse and updates a two-bit result code that reports whether every result byte was zero. The engine talks to a single-port byte RAM with a combinational read path and a fault input. A fault on any access ends the operation at once and is reported with the completion pulse. The engine requests no memory lock, so the read and the write of one destination byte are separate accesses.

Top module: `sx_engine`

## Requirements
- R1: Each stored byte equals the destination byte XOR the source byte. A result bit is one exactly when the two operand bits differ.
- R2: For a field operation, each byte uses three consecutive cycles with one access per cycle. The first is a read at the source address, the second a read at the destination address, and the third a write (`mem_we`=1) at the destination address. Byte offsets rise by one from zero, and addresses wrap modulo 2^AW.
- R3: A length code L processes exactly L+1 bytes, so L=0 processes one byte and L=255 processes 256 bytes.
- R4: Each result byte is written before the next byte's source read. When the fields overlap, later bytes therefore read results that were already stored.
- R5: In the immediate mode (`imm_mode`=1 at start), the source is `imm_data`. The engine makes one destination read and then one write of that byte, whatever the value of `len_code`.
- R6: After a completed operation, `cc` is 0 when every result byte is zero and 1 otherwise. It never takes the values 2 or 3, and it keeps its value until the next completion.
- R7: When the source and destination addresses are equal, the field becomes all zeros and `cc` becomes 0.
- R8: If `mem_fault` is high during any access (source read, destination read or destination write), the engine makes no further access. In the next cycle it asserts `done` and `fault` together, and `cc` keeps its previous value.
- R9: A start pulse that arrives while an operation is in progress is ignored.
- R10: During and right after reset, `mem_req`, `done` and `fault` are 0 and `cc` is 0.
- R11: `done` is a single-cycle pulse that appears in the cycle after the last access of the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| imm_mode | input | 1 | 1 selects the one-byte immediate variant |
| dst_addr | input | AW | Destination (first operand) start address |
| src_addr | input | AW | Source (second operand) start address |
| len_code | input | LW | Byte count minus one |
| imm_data | input | 8 | Immediate source byte |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Access address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the access cycle |
| mem_fault | input | 1 | Access fault for the current access |
| done | output | 1 | Completion pulse |
| fault | output | 1 | Operation ended by an access fault (with done) |
| cc | output | 2 | Result code: 0 all zero, 1 nonzero |

## Verification
Fault termination and normal completion can fall in the same cycle when the store of the final byte faults. The bench provokes this with a fault window that hits only writes, placed on the last destination address of a field and of an immediate operation. It then checks that `done` and `fault` rise together one cycle later, that `cc` keeps the value from the preceding successful operation, and that the faulted byte keeps its old contents while the earlier bytes hold their results.

// File: rtl/sx_pkg.sv
package sx_pkg;

    typedef enum logic [1:0] {
        SX_IDLE      = 2'd0,
        SX_FETCH_SRC = 2'd1,
        SX_FETCH_DST = 2'd2,
        SX_STORE     = 2'd3
    } sx_state_e;

    localparam logic [1:0] SX_CC_ZERO    = 2'd0;
    localparam logic [1:0] SX_CC_NONZERO = 2'd1;

    typedef struct packed {
        logic [7:0] dst;
        logic [7:0] src;
    } sx_pair_t;

    typedef struct packed {
        logic finish;
        logic abort;
    } sx_end_t;

    function automatic logic [7:0] sx_combine(input sx_pair_t p);
        return p.dst ^ p.src;
    endfunction

    function automatic logic [1:0] sx_code(input logic nonzero);
        return nonzero ? SX_CC_NONZERO : SX_CC_ZERO;
    endfunction

endpackage

// File: rtl/sx_ctrl.sv
module sx_ctrl
    import sx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      imm,
    input  logic      last,
    input  logic      mem_fault,
    output sx_state_e state,
    output logic      launch,
    output logic      adv,
    output sx_end_t   ends,
    output logic      done,
    output logic      fault
);

    sx_state_e nxt;

    always_comb begin
        nxt    = state;
        launch = 1'b0;
        adv    = 1'b0;
        ends   = '0;
        case (state)
            SX_IDLE: begin
                if (start) begin
                    launch = 1'b1;
                    nxt    = imm ? SX_FETCH_DST : SX_FETCH_SRC;
                end
            end
            SX_FETCH_SRC: begin
                if (mem_fault) begin
                    ends.abort = 1'b1;
                    nxt        = SX_IDLE;
                end else begin
                    nxt = SX_FETCH_DST;
                end
            end
            SX_FETCH_DST: begin
                if (mem_fault) begin
                    ends.abort = 1'b1;
                    nxt        = SX_IDLE;
                end else begin
                    nxt = SX_STORE;
                end
            end
            SX_STORE: begin
                if (mem_fault) begin
                    ends.abort = 1'b1;
                    nxt        = SX_IDLE;
                end else if (last) begin
                    ends.finish = 1'b1;
                    nxt         = SX_IDLE;
                end else begin
                    adv = 1'b1;
                    nxt = SX_FETCH_SRC;
                end
            end
            default: nxt = SX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SX_IDLE;
            done  <= 1'b0;
            fault <= 1'b0;
        end else begin
            state <= nxt;
            done  <= ends.finish | ends.abort;
            fault <= ends.abort;
        end
    end

endmodule

// File: rtl/sx_addr_gen.sv
module sx_addr_gen #(
    parameter int AW = 16,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          imm,
    input  logic [AW-1:0] dst_in,
    input  logic [AW-1:0] src_in,
    input  logic [LW-1:0] len_in,
    input  logic          adv,
    input  logic          sel_src,
    output logic [AW-1:0] addr,
    output logic          last
);

    logic [AW-1:0] dst_base;
    logic [AW-1:0] src_base;
    logic [LW-1:0] len_q;
    logic [LW-1:0] off;

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_base <= '0;
            src_base <= '0;
            len_q    <= '0;
            off      <= '0;
        end else if (load) begin
            dst_base <= dst_in;
            src_base <= src_in;
            len_q    <= imm ? '0 : len_in;
            off      <= '0;
        end else if (adv) begin
            off <= off + 1'b1;
        end
    end

    assign addr = (sel_src ? src_base : dst_base) + AW'(off);
    assign last = (off == len_q);

endmodule

// File: rtl/sx_cc_acc.sv
module sx_cc_acc
    import sx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       acc_en,
    input  logic       commit,
    input  logic [7:0] res_byte,
    output logic [1:0] cc
);

    logic nz;
    logic nz_next;

    assign nz_next = nz | (acc_en & (|res_byte));

    always_ff @(posedge clk) begin
        if (rst) begin
            nz <= 1'b0;
            cc <= SX_CC_ZERO;
        end else begin
            if (clear) begin
                nz <= 1'b0;
            end else if (acc_en) begin
                nz <= nz_next;
            end
            if (commit) begin
                cc <= sx_code(nz_next);
            end
        end
    end

endmodule

// File: rtl/sx_engine.sv
module sx_engine
    import sx_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          imm_mode,
    input  logic [AW-1:0] dst_addr,
    input  logic [AW-1:0] src_addr,
    input  logic [LW-1:0] len_code,
    input  logic [7:0]    imm_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    input  logic          mem_fault,
    output logic          done,
    output logic          fault,
    output logic [1:0]    cc
);

    sx_state_e state;
    sx_end_t   ends;
    sx_pair_t  pair_q;
    logic      launch;
    logic      adv;
    logic      last;

    sx_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .imm       (imm_mode),
        .last      (last),
        .mem_fault (mem_fault),
        .state     (state),
        .launch    (launch),
        .adv       (adv),
        .ends      (ends),
        .done      (done),
        .fault     (fault)
    );

    sx_addr_gen #(.AW(AW), .LW(LW)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .load    (launch),
        .imm     (imm_mode),
        .dst_in  (dst_addr),
        .src_in  (src_addr),
        .len_in  (len_code),
        .adv     (adv),
        .sel_src (state == SX_FETCH_SRC),
        .addr    (mem_addr),
        .last    (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= '0;
        end else begin
            if (launch && imm_mode) begin
                pair_q.src <= imm_data;
            end
            if (state == SX_FETCH_SRC && !mem_fault) begin
                pair_q.src <= mem_rdata;
            end
            if (state == SX_FETCH_DST && !mem_fault) begin
                pair_q.dst <= mem_rdata;
            end
        end
    end

    assign mem_req   = (state != SX_IDLE);
    assign mem_we    = (state == SX_STORE);
    assign mem_wdata = sx_combine(pair_q);

    sx_cc_acc u_cc (
        .clk      (clk),
        .rst      (rst),
        .clear    (launch),
        .acc_en   ((state == SX_STORE) && !mem_fault),
        .commit   (ends.finish),
        .res_byte (mem_wdata),
        .cc       (cc)
    );

endmodule

// File: rtl/sx_engine_chk.sv
module sx_engine_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_fault,
    input logic          done,
    input logic          fault,
    input logic [1:0]    cc
);

    p_store_is_access_r2: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req);

    p_store_after_read_r4: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ($past(mem_req) && !$past(mem_we)));

    p_fault_halts_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_fault) |=> (!mem_req && done && fault));

    p_fault_with_done_r8: assert property (@(posedge clk) disable iff (rst)
        fault |-> done);

    p_fault_keeps_cc_r8: assert property (@(posedge clk) disable iff (rst)
        fault |-> $stable(cc));

    p_cc_legal_r6: assert property (@(posedge clk) disable iff (rst)
        cc[1] == 1'b0);

    p_cc_held_r6: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(cc));

    p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_idle_on_done_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req);

endmodule

bind sx_engine sx_engine_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_fault (mem_fault),
    .done      (done),
    .fault     (fault),
    .cc        (cc)
);

// File: tb/tb_sx_engine.sv
`timescale 1ns/1ps
module tb_sx_engine;

    localparam int AW  = 10;
    localparam int LW  = 8;
    localparam int MEM = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic          imm_mode;
    logic [AW-1:0] dst_addr;
    logic [AW-1:0] src_addr;
    logic [LW-1:0] len_code;
    logic [7:0]    imm_data;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata;
    logic          mem_fault;
    logic          done;
    logic          fault;
    logic [1:0]    cc;

    always #4 clk = ~clk;

    sx_engine #(.AW(AW), .LW(LW)) dut (
        .clk(clk), .rst(rst), .start(start), .imm_mode(imm_mode),
        .dst_addr(dst_addr), .src_addr(src_addr), .len_code(len_code),
        .imm_data(imm_data), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_fault(mem_fault), .done(done), .fault(fault), .cc(cc)
    );

    logic [7:0] mem     [MEM];
    logic [7:0] ref_mem [MEM];
    logic fault_en;
    logic fault_wr_only;
    int   flo;
    int   fhi;

    assign mem_rdata = mem[mem_addr];
    assign mem_fault = fault_en && mem_req && (int'(mem_addr) >= flo) &&
                       (int'(mem_addr) <= fhi) && (!fault_wr_only || mem_we);

    typedef struct {
        bit         we;
        int         addr;
        logic [7:0] data;
    } acc_t;

    acc_t q[$];
    int   checks   = 0;
    int   failures = 0;
    bit   finished = 0;
    bit   fin_next;
    bit   seen_end;
    bit   exp_fault;
    logic [1:0] exp_cc;
    logic [1:0] pend_cc;
    int   wr_seen;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit hit(input int a, input bit we);
        return fault_en && a >= flo && a <= fhi && (!fault_wr_only || we);
    endfunction

    task automatic setm(input int a, input logic [7:0] v);
        mem[a]     = v;
        ref_mem[a] = v;
    endtask

    // Reference model: expected access list for one operation, byte-serial
    task automatic plan(input bit imm, input int d, input int s, input int l,
                        input logic [7:0] iv);
        int n;
        bit nz;
        bit f;
        n  = imm ? 1 : l + 1;
        nz = 0;
        f  = 0;
        for (int i = 0; i < n; i++) begin
            int a1;
            int a2;
            logic [7:0] b2;
            logic [7:0] r;
            a1 = (d + i) % MEM;
            a2 = (s + i) % MEM;
            if (!imm) begin
                q.push_back('{0, a2, 8'h00});
                if (hit(a2, 0)) begin f = 1; break; end
                b2 = ref_mem[a2];
            end else begin
                b2 = iv;
            end
            q.push_back('{0, a1, 8'h00});
            if (hit(a1, 0)) begin f = 1; break; end
            r = ref_mem[a1] ^ b2;
            q.push_back('{1, a1, r});
            if (hit(a1, 1)) begin f = 1; break; end
            ref_mem[a1] = r;
            nz = nz | (r != 8'h00);
        end
        exp_fault = f;
        pend_cc   = f ? exp_cc : (nz ? 2'd1 : 2'd0);
    endtask

    // One cycle of comparison against the model, sampled at the falling edge
    task automatic tick();
        @(negedge clk);
        if (q.size() != 0) begin
            acc_t e;
            e = q.pop_front();
            chk(mem_req === 1'b1, "R2", "mem_req", int'(mem_req), 1);
            chk(mem_we === e.we, "R2", "mem_we", int'(mem_we), int'(e.we));
            chk(int'(mem_addr) == e.addr, "R2", "mem_addr", int'(mem_addr), e.addr);
            if (e.we) begin
                chk(mem_wdata === e.data, "R1", "mem_wdata", int'(mem_wdata), int'(e.data));
                if (mem_we && !mem_fault) begin
                    mem[mem_addr] = mem_wdata;
                    wr_seen++;
                end
            end
            chk(done === 1'b0, "R11", "done busy", int'(done), 0);
            chk(cc === exp_cc, "R6", "cc busy", int'(cc), int'(exp_cc));
            if (q.size() == 0) fin_next = 1;
        end else begin
            chk(mem_req === 1'b0, "R2", "mem_req idle", int'(mem_req), 0);
            if (fin_next) begin
                chk(done === 1'b1, "R11", "done", int'(done), 1);
                chk(fault === exp_fault, "R8", "fault", int'(fault), int'(exp_fault));
                chk(cc === pend_cc, "R6", "cc final", int'(cc), int'(pend_cc));
                exp_cc   = pend_cc;
                fin_next = 0;
                seen_end = 1;
            end else begin
                chk(done === 1'b0, "R11", "done idle", int'(done), 0);
                chk(fault === 1'b0, "R8", "fault idle", int'(fault), 0);
                chk(cc === exp_cc, "R6", "cc held", int'(cc), int'(exp_cc));
            end
        end
    endtask

    task automatic mem_match(input string tag);
        int bad;
        bad = -1;
        for (int i = 0; i < MEM; i++) begin
            if (bad < 0 && mem[i] !== ref_mem[i]) bad = i;
        end
        chk(bad < 0, tag, "memory image", bad < 0 ? 0 : int'(mem[bad]),
            bad < 0 ? 0 : int'(ref_mem[bad]));
    endtask

    task automatic run_op(input bit imm, input int d, input int s, input int l,
                          input logic [7:0] iv, input bit poke, input string tag);
        @(negedge clk);
        #1;
        imm_mode = imm;
        dst_addr = AW'(d);
        src_addr = AW'(s);
        len_code = LW'(l);
        imm_data = iv;
        start    = 1'b1;
        seen_end = 0;
        fin_next = 0;
        wr_seen  = 0;
        plan(imm, d, s, l, iv);
        tick();
        #1;
        start = 1'b0;
        if (poke) begin
            // R9: second start while busy must be ignored
            start    = 1'b1;
            imm_mode = 1'b1;
            dst_addr = AW'(d + 5);
            imm_data = 8'hFF;
            tick();
            #1;
            start = 1'b0;
        end
        while (!seen_end) tick();
        tick();
        mem_match(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0; imm_mode = 1'b0;
        dst_addr = '0; src_addr = '0; len_code = '0; imm_data = '0;
        fault_en = 1'b0; fault_wr_only = 1'b0; flo = 0; fhi = -1;
        exp_cc = 2'd0; pend_cc = 2'd0; exp_fault = 0;
        fin_next = 0; seen_end = 0; wr_seen = 0;
        for (int i = 0; i < MEM; i++) begin
            logic [7:0] v;
            v = 8'((i * 37 + 11) ^ (i >> 3));
            mem[i]     = v;
            ref_mem[i] = v;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk(mem_req === 1'b0, "R10", "mem_req", int'(mem_req), 0);
        chk(done === 1'b0, "R10", "done", int'(done), 0);
        chk(fault === 1'b0, "R10", "fault", int'(fault), 0);
        chk(cc === 2'd0, "R10", "cc", int'(cc), 0);

        // R1 R2: plain field
        run_op(0, 'h100, 'h200, 7, 8'h00, 0, "R1");

        // R7: field with itself
        run_op(0, 'h040, 'h040, 15, 8'h00, 0, "R7");
        chk(cc === 2'd0, "R7", "cc self", int'(cc), 0);
        for (int i = 0; i < 16; i++)
            chk(mem['h040 + i] === 8'h00, "R7", "self byte", int'(mem['h040 + i]), 0);

        // R5: immediate variant, length code must not matter
        run_op(1, 'h150, 'h000, 9, 8'h5A, 0, "R5");
        chk(wr_seen == 1, "R5", "imm writes", wr_seen, 1);
        setm('h151, 8'h3C);
        run_op(1, 'h151, 'h000, 0, 8'h3C, 0, "R5");
        chk(cc === 2'd0, "R6", "cc zero result", int'(cc), 0);
        chk(mem['h151] === 8'h00, "R5", "imm result", int'(mem['h151]), 0);

        // R4: overlapping fields, both directions
        run_op(0, 'h181, 'h180, 9, 8'h00, 0, "R4");
        run_op(0, 'h1C0, 'h1C1, 9, 8'h00, 0, "R4");

        // R3: minimum and maximum length, with address wrap
        run_op(0, 'h010, 'h020, 0, 8'h00, 0, "R3");
        chk(wr_seen == 1, "R3", "L=0 writes", wr_seen, 1);
        run_op(0, 'h200, 'h380, 255, 8'h00, 0, "R3");
        chk(wr_seen == 256, "R3", "L=255 writes", wr_seen, 256);

        // R9: start while busy
        run_op(0, 'h0E0, 'h0F0, 4, 8'h00, 1, "R9");

        // R6: known nonzero result
        setm('h050, 8'h0F);
        setm('h060, 8'hF0);
        run_op(0, 'h050, 'h060, 0, 8'h00, 0, "R6");
        chk(cc === 2'd1, "R6", "cc nonzero", int'(cc), 1);

        // R8: fault on a source read, a destination read, a final store
        fault_en = 1'b1; fault_wr_only = 1'b0; flo = 'h303; fhi = 'h303;
        run_op(0, 'h0A0, 'h300, 7, 8'h00, 0, "R8");
        flo = 'h0B2; fhi = 'h0B2;
        run_op(0, 'h0B0, 'h310, 7, 8'h00, 0, "R8");
        fault_wr_only = 1'b1; flo = 'h0C3; fhi = 'h0C3;
        run_op(0, 'h0C0, 'h320, 3, 8'h00, 0, "R8");
        chk(cc === 2'd1, "R8", "cc kept", int'(cc), 1);
        flo = 'h0D0; fhi = 'h0D0;
        run_op(1, 'h0D0, 'h000, 0, 8'hA5, 0, "R8");
        fault_en = 1'b0;

        // recovery after faults
        run_op(0, 'h240, 'h250, 5, 8'h00, 0, "R1");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule